// File: doc/BRIEF.md
# Rate-Search Acquisition Sequencer

This block is the slow control state machine of a multi-rate serial clock-recovery receiver. It chooses which divider modulus the PLL clock uses and which of two VCO centre ranges is active, and it sequences the frequency acquisition sweep. The analog ramp is not modelled. Two tick inputs mark when a sweep ramp reaches its limit and when a system-clock interval has passed.

In automatic mode an internal rate counter walks through the permitted rate codes. Each code gets one acquisition cycle: an up-sweep, then a down-sweep, then a wait of one system-clock interval. The counter advances at the end of each cycle, and the code is presented on an output. The walk depends on the standard-select input. In manual mode the rate code is taken from an input and the same modulus is retried every cycle.

Sweeping stops and the counter holds while the PLL reports lock, or while no input data is present. Reacquisition therefore starts at the last rate that worked.

Top module: `rate_search_seq`

## Requirements
- R1: During and right after reset, the internal rate counter is 0 and the sequencer is in the up-sweep phase.
- R2: In auto mode with `std_sel` high, each completed acquisition cycle advances `rate_code` by one through 0,1,2,3,4 and wraps from 4 to 0. The code never exceeds 4.
- R3: In auto mode with `std_sel` low, each completed cycle moves the counter to the next even code of 0,2,4, and wraps from 4 to 0. An odd starting value goes to the next higher even code.
- R4: `div_sel` encodes the modulus as 0 = /1, 1 = /2, 2 = /4, 3 = /8. Codes map as follows: 0 gives /4; 1 and 2 give /2; 3 and 4 give /1; 5 and 6 give /8 (reachable only in manual mode).
- R5: `vco_low` is 1 exactly when `std_sel` is 1, bit 0 of the active rate code is 1, and the code is valid.
- R6: An acquisition cycle runs up-sweep (`sweep_up`), then down-sweep (`sweep_dn`), then a wait with both low. A phase ends on `sweep_done` for the sweep phases and on `sys_tick` for the wait. The next cycle starts with an up-sweep, and `sweep_up` and `sweep_dn` are never high together.
- R7: In manual mode `rate_code` follows `man_code`, and the end of a cycle does not change the internal counter.
- R8: While `data_present` is low, sweeping stops, the phase returns to up-sweep, and the counter keeps its value.
- R9: While `locked` is high, both sweep outputs are low and the counter holds. When lock drops with data present, the sweep restarts with an up-sweep at the same code.
- R10: Manual code 7 is invalid. It selects /1 on the high range and raises `code_err`. `code_err` is otherwise low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = automatic rate search, 0 = manual code |
| std_sel | input | 1 | Standard select; picks the search order and enables the low VCO range |
| man_code | input | 3 | Rate code used in manual mode |
| data_present | input | 1 | Input data activity detected |
| locked | input | 1 | PLL lock status |
| sweep_done | input | 1 | Pulse: current sweep ramp reached its limit |
| sys_tick | input | 1 | Pulse: one system-clock interval elapsed |
| rate_code | output | 3 | Active rate code (counter in auto, `man_code` in manual) |
| div_sel | output | 2 | Divider modulus select |
| vco_low | output | 1 | 1 = low VCO centre range |
| sweep_up | output | 1 | Ramp the VCO control upward |
| sweep_dn | output | 1 | Ramp the VCO control downward |
| code_err | output | 1 | Invalid manual rate code |

## Verification
On every cycle the assertions check several properties. The sweep controls are exclusive and stay quiet under lock. The auto counter stays in range and does not move while held. A step with `std_sel` low lands on an even code. The range and error outputs obey their decode rules, and a finished cycle is followed by an up-sweep.

Some behaviour only the bench scenarios can show. These are the full walk orders and their wrap points, the resumption at the retained code after data loss or lock, the manual retry behaviour, and every code-to-modulus pairing. For these, a behavioural model is compared against the outputs on each clock.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {PH_UP = 2'd0, PH_DN = 2'd1, PH_WT = 2'd2} phase_t;

  function automatic logic code_bad(input logic [2:0] code, input logic manual);
    return manual && (code == 3'd7);
  endfunction

  function automatic logic [1:0] div_of(input logic [2:0] code, input logic bad);
    logic [1:0] d;
    if (bad) d = 2'd0;
    else begin
      unique case (code)
        3'd0:       d = 2'd2;
        3'd1, 3'd2: d = 2'd1;
        3'd3, 3'd4: d = 2'd0;
        default:    d = 2'd3;
      endcase
    end
    return d;
  endfunction

  function automatic logic low_range(input logic [2:0] code, input logic std, input logic bad);
    return std && code[0] && !bad;
  endfunction

  function automatic logic [2:0] step_code(input logic [2:0] cnt, input logic std,
                                           input logic [2:0] last);
    logic [2:0] n;
    if (cnt >= last)  n = 3'd0;
    else if (std)     n = cnt + 3'd1;
    else              n = {cnt[2:1], 1'b0} + 3'd2;
    return n;
  endfunction
endpackage

// File: rtl/rs_phase_fsm.sv
module rs_phase_fsm
  import rs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  input  logic   sweep_done,
  input  logic   sys_tick,
  output phase_t phase,
  output logic   cycle_end
);
  phase_t phase_nx;

  assign cycle_end = !hold && (phase == PH_WT) && sys_tick;

  always_comb begin
    phase_nx = phase;
    if (hold) phase_nx = PH_UP;
    else begin
      unique case (phase)
        PH_UP:   if (sweep_done) phase_nx = PH_DN;
        PH_DN:   if (sweep_done) phase_nx = PH_WT;
        default: if (sys_tick)   phase_nx = PH_UP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_UP;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/rs_rate_counter.sv
module rs_rate_counter
  import rs_pkg::*;
#(
  parameter int CW   = 3,
  parameter int LAST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          std_sel,
  output logic [CW-1:0] cnt
);
  localparam logic [2:0] LAST_C = 3'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= CW'(step_code(3'(cnt), std_sel, LAST_C));
  end
endmodule

// File: rtl/rs_decode.sv
module rs_decode
  import rs_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] code,
  input  logic          std_sel,
  input  logic          manual,
  output logic [1:0]    div_sel,
  output logic          vco_low,
  output logic          bad
);
  assign bad     = code_bad(3'(code), manual);
  assign div_sel = div_of(3'(code), bad);
  assign vco_low = low_range(3'(code), std_sel, bad);
endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
  import rs_pkg::*;
#(
  parameter int CW   = 3,
  parameter int LAST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_mode,
  input  logic          std_sel,
  input  logic [CW-1:0] man_code,
  input  logic          data_present,
  input  logic          locked,
  input  logic          sweep_done,
  input  logic          sys_tick,
  output logic [CW-1:0] rate_code,
  output logic [1:0]    div_sel,
  output logic          vco_low,
  output logic          sweep_up,
  output logic          sweep_dn,
  output logic          code_err
);
  phase_t        phase;
  logic          hold;
  logic          cycle_end;
  logic          step;
  logic [CW-1:0] cnt;

  assign hold = locked || !data_present;
  assign step = cycle_end && auto_mode;

  rs_phase_fsm u_phase (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sweep_done(sweep_done),
    .sys_tick(sys_tick), .phase(phase), .cycle_end(cycle_end)
  );

  rs_rate_counter #(.CW(CW), .LAST(LAST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .std_sel(std_sel), .cnt(cnt)
  );

  assign rate_code = auto_mode ? cnt : man_code;

  rs_decode #(.CW(CW)) u_dec (
    .code(rate_code), .std_sel(std_sel), .manual(!auto_mode),
    .div_sel(div_sel), .vco_low(vco_low), .bad(code_err)
  );

  assign sweep_up = !hold && (phase == PH_UP);
  assign sweep_dn = !hold && (phase == PH_DN);
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int CW   = 3,
  parameter int LAST = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_mode,
  input logic          std_sel,
  input logic          data_present,
  input logic          locked,
  input logic [CW-1:0] rate_code,
  input logic [1:0]    div_sel,
  input logic          vco_low,
  input logic          sweep_up,
  input logic          sweep_dn,
  input logic          code_err,
  input logic          cycle_end
);
  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sweep_up, sweep_dn}));
  p_restart_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (sweep_up || locked || !data_present));
  p_lock_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!sweep_up && !sweep_dn));
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && locked) |=> (!auto_mode || rate_code == $past(rate_code)));
  p_loss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !data_present) |=> (!auto_mode || rate_code == $past(rate_code)));
  p_auto_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode |-> (rate_code <= CW'(LAST)));
  p_even_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && auto_mode && !std_sel) |=> (!auto_mode || !rate_code[0]));
  p_low_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vco_low |-> (std_sel && rate_code[0]));
  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (div_sel == 2'd0 && !vco_low && !auto_mode));
endmodule

bind rate_search_seq rs_checker #(.CW(CW), .LAST(LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .std_sel(std_sel),
  .data_present(data_present), .locked(locked), .rate_code(rate_code),
  .div_sel(div_sel), .vco_low(vco_low), .sweep_up(sweep_up),
  .sweep_dn(sweep_dn), .code_err(code_err), .cycle_end(cycle_end)
);

// File: tb/sim_rate_search_seq.sv
`timescale 1ns/1ps
module sim_rate_search_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_mode = 1'b1, std_sel = 1'b1, data_present = 1'b1, locked = 1'b0;
  logic       sweep_done = 1'b0, sys_tick = 1'b0;
  logic [2:0] man_code = 3'd0;
  logic [2:0] rate_code;
  logic [1:0] div_sel;
  logic       vco_low, sweep_up, sweep_dn, code_err;

  int errors = 0, checks = 0, cycles = 0;
  int m_ph = 0, m_cnt = 0;
  string ctx = "R2";
  logic [7:0] lfsr = 8'h5A;

  always #2 clk = ~clk;

  rate_search_seq u0 (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .std_sel(std_sel),
    .man_code(man_code), .data_present(data_present), .locked(locked),
    .sweep_done(sweep_done), .sys_tick(sys_tick), .rate_code(rate_code),
    .div_sel(div_sel), .vco_low(vco_low), .sweep_up(sweep_up),
    .sweep_dn(sweep_dn), .code_err(code_err)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int modulus(input int code);
    case (code)
      0: return 4;
      1, 2: return 2;
      3, 4: return 1;
      5, 6: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic compare_all();
    int code, m;
    bit bad, hold;
    code = auto_mode ? m_cnt : int'(man_code);
    bad  = !auto_mode && code == 7;
    m    = bad ? 1 : modulus(code);
    hold = locked || !data_present;
    cmp(auto_mode ? ctx : "R7", rate_code, code);
    cmp("R4", div_sel, $clog2(m));
    cmp("R5", vco_low, (std_sel && (code % 2 == 1) && !bad) ? 1 : 0);
    cmp("R10", code_err, bad ? 1 : 0);
    cmp(hold ? ctx : "R6", sweep_up, (!hold && m_ph == 0) ? 1 : 0);
    cmp(hold ? ctx : "R6", sweep_dn, (!hold && m_ph == 1) ? 1 : 0);
  endtask

  task automatic model_edge();
    if (locked || !data_present) m_ph = 0;
    else if (m_ph == 0) begin if (sweep_done) m_ph = 1; end
    else if (m_ph == 1) begin if (sweep_done) m_ph = 2; end
    else if (sys_tick) begin
      m_ph = 0;
      if (auto_mode) begin
        if (std_sel) m_cnt = (m_cnt >= 4) ? 0 : m_cnt + 1;
        else if (m_cnt < 2) m_cnt = 2;
        else if (m_cnt < 4) m_cnt = 4;
        else m_cnt = 0;
      end
    end
  endtask

  task automatic cyc(input bit sd, input bit st);
    sweep_done = sd; sys_tick = st;
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cyc(lfsr[0], lfsr[2]);
      end else cyc(i % 3 == 2, i % 2 == 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    #1;
    cmp("R1", rate_code, 0);
    cmp("R1", sweep_up, 1);
    @(negedge clk);
    rst_n = 1'b1;
    ctx = "R1";
    cyc(0, 0);
    ctx = "R2"; run(120, 0); run(80, 1);
    ctx = "R9"; locked = 1'b1; run(20, 0);
    locked = 1'b0; cyc(0, 0);
    run(30, 1);
    ctx = "R8"; data_present = 1'b0; run(20, 1);
    data_present = 1'b1; run(25, 0);
    ctx = "R3"; std_sel = 1'b0; run(100, 0); run(60, 1);
    ctx = "R9"; locked = 1'b1; run(10, 1); locked = 1'b0; run(10, 0);
    ctx = "R7"; auto_mode = 1'b0;
    for (int s = 0; s < 2; s++) begin
      std_sel = (s == 1);
      for (int c = 0; c < 8; c++) begin
        man_code = 3'(c);
        run(15, 0);
      end
    end
    ctx = "R2"; auto_mode = 1'b1; std_sel = 1'b1; run(40, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule